// File: doc/BRIEF.md
# Shadow-RAM Configuration Decoder

This block is the configuration unit of a legacy PC chipset. Software reaches it through an I/O slave interface. An index port selects one of 256 byte-wide configuration registers, and a data port next to it reads or writes the selected register. A separate read-only port returns a strap byte. That byte records how the board was set up when reset was released.

One register (index 02h) controls shadow RAM for the upper-memory area. It has one enable bit for each of five windows, a global enable bit and a cacheability bit. For any 20-bit memory address it is given, the block looks up the window and answers two things: whether reads and writes to that address go to internal shadow RAM, and whether the location is cacheable. Accesses below C0000h always go to the external bus.

I/O reads return their data one clock after the request, together with a valid flag. The region lookup is combinational from the address and the stored control byte.

Top module: `shadow_cfg_unit`

## Requirements
- R1: A write to I/O address 00F2h stores the low 8 bits of write data as the register index, and a read of 00F2h returns the current index.
- R2: A write to I/O address 00F3h stores the data byte in the register selected by the index. A read of 00F3h returns that register. All 256 registers hold their values independently.
- R3: A read of 00F2h, 00F3h or 0078h raises io_rvalid for exactly the one cycle after io_rd, with the data on io_rdata. A read of any other address leaves io_rvalid low and io_rdata at 0.
- R4: For mem_addr below C0000h, route_internal and cacheable are both 0, whatever the control byte holds.
- R5: The control byte is register 02h. Its bit 0 enables window C0000h–C7FFFh, bit 1 enables C8000h–CFFFFh, bit 2 enables D0000h–DFFFFh, bit 3 enables E0000h–EFFFFh and bit 4 enables F0000h–FFFFFh. An enabled window gives route_internal=1 when bit 5 is also set.
- R6: When bit 5 of register 02h is 0, route_internal is 0 at every address.
- R7: cacheable is 1 exactly when route_internal is 1 and bit 6 of register 02h is 1.
- R8: A read of 0078h returns the strap byte. Bit 7 is the super I/O enable strap, bit 6 is the standalone-graphics strap, and the other bits are 0. The straps are captured only while rst is high, and writes to 0078h have no effect.
- R9: The routing outputs change in the cycle after a data-port write to index 02h. Data writes to any other index leave the routing unchanged.
- R10: Reset sets the index and all 256 registers to 0, so every upper-memory access routes externally after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; straps are captured while it is high |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | Registered I/O read data |
| io_rvalid | output | 1 | Read claimed; high the cycle after a read to an owned port |
| strap_sio_en | input | 1 | Super I/O enable strap |
| strap_ext_gfx | input | 1 | Standalone graphics strap |
| mem_addr | input | 20 | Memory address to classify |
| route_internal | output | 1 | Access goes to internal shadow RAM |
| cacheable | output | 1 | Access is cacheable |

## Verification
The region lookup is swept across both edges of every window boundary and the last address below C0000h. The sweep is repeated for these control bytes:
- all window bits with the global bit clear, which isolates the gating;
- all window bits with the global bit set, with and without the cache bit;
- a sparse mix of window bits, which exposes swapped or merged windows.

Writes to indices other than 02h, and to the strap port, are followed by the same sweep and by readback to show they change nothing. A full 256-entry write-then-read pass separates distinct register storage from aliasing. Two resets with different strap levels, with the straps moved between them, show that capture happens only during reset.

// File: rtl/shadow_cfg_pkg.sv
package shadow_cfg_pkg;
  localparam int unsigned NWIN      = 5;
  localparam int unsigned CTL_INDEX = 2;
  localparam int unsigned GLOBAL_EN = 5;
  localparam int unsigned CACHE_EN  = 6;

  typedef enum logic [2:0] {
    WIN_C0   = 3'd0,
    WIN_C8   = 3'd1,
    WIN_D0   = 3'd2,
    WIN_E0   = 3'd3,
    WIN_F0   = 3'd4,
    WIN_NONE = 3'd7
  } win_e;

  // top5 = the five most significant bits of a 20-bit address
  function automatic win_e classify(input logic [4:0] top5);
    win_e w;
    if (top5[4:3] != 2'b11)      w = WIN_NONE;
    else if (top5[2:0] == 3'b000) w = WIN_C0;
    else if (top5[2:0] == 3'b001) w = WIN_C8;
    else if (top5[2:1] == 2'b01)  w = WIN_D0;
    else if (top5[2:1] == 2'b10)  w = WIN_E0;
    else                          w = WIN_F0;
    return w;
  endfunction
endpackage

// File: rtl/io_port_match.sv
module io_port_match #(
  parameter int unsigned   IO_AW      = 16,
  parameter logic [15:0]   INDEX_PORT = 16'h00F2,
  parameter logic [15:0]   STRAP_PORT = 16'h0078
) (
  input  logic [IO_AW-1:0] io_addr,
  output logic             hit_index,
  output logic             hit_data,
  output logic             hit_strap
);
  localparam logic [IO_AW-1:0] IDX_A  = IO_AW'(INDEX_PORT);
  localparam logic [IO_AW-1:0] DAT_A  = IO_AW'(INDEX_PORT | 16'h0001);
  localparam logic [IO_AW-1:0] STR_A  = IO_AW'(STRAP_PORT);

  always_comb begin
    hit_index = (io_addr == IDX_A);
    hit_data  = (io_addr == DAT_A);
    hit_strap = (io_addr == STR_A);
  end
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
  import shadow_cfg_pkg::*;
#(
  parameter int unsigned DW   = 8,
  parameter int unsigned NREG = 256
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          idx_wr,
  input  logic          dat_wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] index_byte,
  output logic [DW-1:0] sel_byte,
  output logic [DW-1:0] ctl_byte
);
  localparam int unsigned IW = $clog2(NREG);

  logic [IW-1:0] idx_q;
  logic [DW-1:0] bank_q [NREG];
  logic [DW-1:0] ctl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
    end else if (idx_wr) begin
      idx_q <= wdata[IW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) bank_q[i] <= '0;
    end else if (dat_wr) begin
      bank_q[idx_q] <= wdata;
    end
  end

  // dedicated copy of the shadow control byte feeding the region decoder
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
    end else if (dat_wr && (idx_q == IW'(CTL_INDEX))) begin
      ctl_q <= wdata;
    end
  end

  always_comb begin
    index_byte = DW'(idx_q);
    sel_byte   = bank_q[idx_q];
    ctl_byte   = ctl_q;
  end
endmodule

// File: rtl/strap_latch.sv
module strap_latch #(
  parameter int unsigned DW      = 8,
  parameter int unsigned SIO_BIT = 7,
  parameter int unsigned GFX_BIT = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sio_en,
  input  logic          ext_gfx,
  output logic [DW-1:0] strap_byte
);
  logic [DW-1:0] strap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      strap_q          <= '0;
      strap_q[SIO_BIT] <= sio_en;
      strap_q[GFX_BIT] <= ext_gfx;
    end
  end

  assign strap_byte = strap_q;
endmodule

// File: rtl/region_decoder.sv
module region_decoder
  import shadow_cfg_pkg::*;
#(
  parameter int unsigned MEM_AW = 20,
  parameter int unsigned DW     = 8
) (
  input  logic [MEM_AW-1:0] mem_addr,
  input  logic [DW-1:0]     ctl,
  output logic              route_internal,
  output logic              cacheable
);
  win_e            win;
  logic [NWIN-1:0] win_hit;
  logic [NWIN-1:0] win_on;

  assign win = classify(mem_addr[MEM_AW-1 -: 5]);

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    assign win_hit[g] = (win == win_e'(g));
    assign win_on[g]  = win_hit[g] & ctl[g];
  end

  always_comb begin
    route_internal = (|win_on) & ctl[GLOBAL_EN];
    cacheable      = route_internal & ctl[CACHE_EN];
  end
endmodule

// File: rtl/shadow_cfg_unit.sv
module shadow_cfg_unit #(
  parameter int unsigned IO_AW      = 16,
  parameter int unsigned DW         = 8,
  parameter int unsigned NREG       = 256,
  parameter int unsigned MEM_AW     = 20,
  parameter logic [15:0] INDEX_PORT = 16'h00F2,
  parameter logic [15:0] STRAP_PORT = 16'h0078
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IO_AW-1:0]  io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [DW-1:0]     io_wdata,
  output logic [DW-1:0]     io_rdata,
  output logic              io_rvalid,
  input  logic              strap_sio_en,
  input  logic              strap_ext_gfx,
  input  logic [MEM_AW-1:0] mem_addr,
  output logic              route_internal,
  output logic              cacheable
);
  logic          hit_index, hit_data, hit_strap;
  logic [DW-1:0] index_byte, sel_byte, ctl_byte, strap_byte;

  io_port_match #(
    .IO_AW(IO_AW), .INDEX_PORT(INDEX_PORT), .STRAP_PORT(STRAP_PORT)
  ) u_match (
    .io_addr  (io_addr),
    .hit_index(hit_index),
    .hit_data (hit_data),
    .hit_strap(hit_strap)
  );

  cfg_regfile #(.DW(DW), .NREG(NREG)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .idx_wr    (io_wr & hit_index),
    .dat_wr    (io_wr & hit_data),
    .wdata     (io_wdata),
    .index_byte(index_byte),
    .sel_byte  (sel_byte),
    .ctl_byte  (ctl_byte)
  );

  strap_latch #(.DW(DW)) u_strap (
    .clk       (clk),
    .rst       (rst),
    .sio_en    (strap_sio_en),
    .ext_gfx   (strap_ext_gfx),
    .strap_byte(strap_byte)
  );

  region_decoder #(.MEM_AW(MEM_AW), .DW(DW)) u_dec (
    .mem_addr      (mem_addr),
    .ctl           (ctl_byte),
    .route_internal(route_internal),
    .cacheable     (cacheable)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      io_rdata  <= '0;
      io_rvalid <= 1'b0;
    end else begin
      io_rvalid <= io_rd & (hit_index | hit_data | hit_strap);
      if (io_rd & hit_index)      io_rdata <= index_byte;
      else if (io_rd & hit_data)  io_rdata <= sel_byte;
      else if (io_rd & hit_strap) io_rdata <= strap_byte;
      else                        io_rdata <= '0;
    end
  end
endmodule

// File: rtl/shadow_cfg_chk.sv
module shadow_cfg_chk #(
  parameter int unsigned IO_AW  = 16,
  parameter int unsigned DW     = 8,
  parameter int unsigned MEM_AW = 20
) (
  input logic              clk,
  input logic              rst,
  input logic [IO_AW-1:0]  io_addr,
  input logic              io_wr,
  input logic              io_rd,
  input logic              io_rvalid,
  input logic [DW-1:0]     io_rdata,
  input logic [MEM_AW-1:0] mem_addr,
  input logic              route_internal,
  input logic              cacheable,
  input logic [DW-1:0]     ctl_byte,
  input logic [DW-1:0]     index_byte,
  input logic [DW-1:0]     strap_byte
);
  localparam logic [IO_AW-1:0] DATA_A = IO_AW'(16'h00F3);
  localparam logic [MEM_AW-1:0] UMA   = MEM_AW'(20'hC0000);

  p_rvalid_follows_rd_r3: assert property (@(posedge clk) disable iff (rst)
    io_rvalid |-> $past(io_rd));

  p_rdata_idle_zero_r3: assert property (@(posedge clk) disable iff (rst)
    !io_rvalid |-> (io_rdata == '0));

  p_low_external_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_addr < UMA) |-> (!route_internal && !cacheable));

  p_global_gate_r6: assert property (@(posedge clk) disable iff (rst)
    !ctl_byte[5] |-> !route_internal);

  p_cache_needs_route_r7: assert property (@(posedge clk) disable iff (rst)
    cacheable |-> (route_internal && ctl_byte[6]));

  p_ctl_only_on_idx2_r9: assert property (@(posedge clk) disable iff (rst)
    !(io_wr && io_addr == DATA_A && index_byte == DW'(2)) |=> $stable(ctl_byte));

  p_strap_held_r8: assert property (@(posedge clk) disable iff (rst || $past(rst))
    1'b1 |=> $stable(strap_byte));
endmodule

bind shadow_cfg_unit shadow_cfg_chk #(.IO_AW(IO_AW), .DW(DW), .MEM_AW(MEM_AW)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .io_addr       (io_addr),
  .io_wr         (io_wr),
  .io_rd         (io_rd),
  .io_rvalid     (io_rvalid),
  .io_rdata      (io_rdata),
  .mem_addr      (mem_addr),
  .route_internal(route_internal),
  .cacheable     (cacheable),
  .ctl_byte      (ctl_byte),
  .index_byte    (index_byte),
  .strap_byte    (strap_byte)
);

// File: tb/test_shadow_cfg_unit.sv
module test_shadow_cfg_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] io_addr = '0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        io_rvalid;
  logic        strap_sio_en = 1'b0, strap_ext_gfx = 1'b0;
  logic [19:0] mem_addr = '0;
  logic        route_internal, cacheable;

  int total = 0;
  int bad = 0;
  bit done = 0;
  string rd_tag = "R1";
  string route_tag = "";

  always #10 clk = ~clk;

  shadow_cfg_unit i_shadow_cfg_unit (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .io_rvalid(io_rvalid),
    .strap_sio_en(strap_sio_en), .strap_ext_gfx(strap_ext_gfx),
    .mem_addr(mem_addr), .route_internal(route_internal), .cacheable(cacheable)
  );

  // behavioural reference state
  logic [7:0] m_regs [256];
  logic [7:0] m_idx;
  logic [7:0] m_strap;
  logic       m_rvalid;
  logic [7:0] m_rdata;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic ref_route(input logic [19:0] a, input logic [7:0] c);
    int b;
    if (a < 20'hC0000) return 1'b0;
    if (a < 20'hC8000) b = 0;
    else if (a < 20'hD0000) b = 1;
    else if (a < 20'hE0000) b = 2;
    else if (a < 20'hF0000) b = 3;
    else b = 4;
    return c[b] & c[5];
  endfunction

  always begin
    @(posedge clk);
    if (rst) begin
      for (int i = 0; i < 256; i++) m_regs[i] = 8'h00;
      m_idx = 8'h00;
      m_strap = {strap_sio_en, strap_ext_gfx, 6'b0};
      m_rvalid = 1'b0;
      m_rdata = 8'h00;
    end else begin
      m_rvalid = 1'b0;
      m_rdata = 8'h00;
      if (io_rd) begin
        if (io_addr == 16'h00F2) begin m_rvalid = 1; m_rdata = m_idx; end
        else if (io_addr == 16'h00F3) begin m_rvalid = 1; m_rdata = m_regs[m_idx]; end
        else if (io_addr == 16'h0078) begin m_rvalid = 1; m_rdata = m_strap; end
      end
      if (io_wr) begin
        if (io_addr == 16'h00F2) m_idx = io_wdata;
        else if (io_addr == 16'h00F3) m_regs[m_idx] = io_wdata;
      end
    end
    #5;
    if (!rst && !done) begin
      logic er;
      string t;
      er = ref_route(mem_addr, m_regs[2]);
      if (route_tag != "") t = route_tag;
      else if (mem_addr < 20'hC0000) t = "R4";
      else if (!m_regs[2][5]) t = "R6";
      else t = "R5";
      chk(t, route_internal, er);
      chk((route_tag != "") ? route_tag : "R7", cacheable, er & m_regs[2][6]);
      chk("R3", io_rvalid, m_rvalid);
      chk(m_rvalid ? rd_tag : "R3", io_rdata, m_rdata);
    end
  end

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic io_read(input logic [15:0] a, input string tag);
    @(negedge clk);
    rd_tag = tag; io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic sweep();
    logic [19:0] pts [13] = '{20'h00000, 20'hBFFFF, 20'hC0000, 20'hC7FFF, 20'hC8000,
                              20'hCFFFF, 20'hD0000, 20'hDFFFF, 20'hE0000, 20'hEFFFF,
                              20'hF0000, 20'hFFFFF, 20'hD8000};
    for (int i = 0; i < 13; i++) begin
      @(negedge clk);
      mem_addr = pts[i];
    end
    @(negedge clk);
  endtask

  task automatic do_reset(input logic sio, input logic gfx);
    @(negedge clk);
    strap_sio_en = sio; strap_ext_gfx = gfx; rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    do_reset(1'b1, 1'b0);
    // R10: reset state of index, register 02h and routing
    io_read(16'h00F2, "R10");
    io_read(16'h00F3, "R10");
    route_tag = "R10";
    sweep();
    route_tag = "";
    // R8: strap byte captured at reset
    io_read(16'h0078, "R8");
    strap_sio_en = 1'b0; strap_ext_gfx = 1'b1;
    io_read(16'h0078, "R8");
    // R1 index readback
    io_write(16'h00F2, 8'hA7);
    io_read(16'h00F2, "R1");
    // R6: windows set, global clear
    io_write(16'h00F2, 8'h02);
    io_write(16'h00F3, 8'h1F);
    sweep();
    // R5: global set, no cache
    io_write(16'h00F3, 8'h3F);
    sweep();
    // R7: cache bit
    io_write(16'h00F3, 8'h7F);
    sweep();
    // R5: sparse windows
    io_write(16'h00F3, 8'h65);
    sweep();
    io_write(16'h00F3, 8'h7A);
    sweep();
    io_read(16'h00F3, "R2");
    // R9: other indices leave routing unchanged
    route_tag = "R9";
    io_write(16'h00F2, 8'h05);
    io_write(16'h00F3, 8'hFF);
    sweep();
    io_write(16'h00F2, 8'h03);
    io_write(16'h00F3, 8'h00);
    sweep();
    io_write(16'h00F2, 8'hFF);
    io_write(16'h00F3, 8'h00);
    sweep();
    route_tag = "";
    // R8: strap port write ignored
    io_write(16'h0078, 8'h3C);
    io_read(16'h0078, "R8");
    // R3: unclaimed reads
    io_read(16'h00F4, "R3");
    io_read(16'h0079, "R3");
    io_read(16'h00F1, "R3");
    // R2: all registers distinct
    for (int i = 0; i < 256; i++) begin
      io_write(16'h00F2, 8'(i));
      io_write(16'h00F3, 8'(i) ^ 8'h5A);
    end
    for (int i = 0; i < 256; i++) begin
      io_write(16'h00F2, 8'(i));
      io_read(16'h00F3, "R2");
    end
    sweep();
    // R10 and R8: second reset with other straps
    do_reset(1'b0, 1'b1);
    io_read(16'h0078, "R8");
    io_read(16'h00F2, "R10");
    io_write(16'h00F2, 8'h02);
    io_read(16'h00F3, "R10");
    route_tag = "R10";
    sweep();
    route_tag = "";
    repeat (2) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule